// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between one 12-bit narrow port (A) and a wide side made of two 12-bit halves (1B and 2B), all on one clock. Going from narrow to wide, two words that arrive one after the other on A are gathered so that they show up together, side by side, as a single 24-bit word on 1B and 2B. Going from wide to narrow, each B half has its own capture register, and a select sampled at the clock edge decides which of the two captured halves drives A.

All registers update on the rising clock edge. Each data register has its own active-low load enable. The narrow-to-1B path uses two register stages. The second of these stages moves forward on the same enable as the 2B register, so the earlier word and the later word leave together. The output enables are active low, and they are also sampled on the clock edge, so a change of bus direction always lines up with the clock. Each bidirectional pin group is split into an input, an output and an output-enable signal. The pads themselves belong to the surrounding chip.

Top module: `bxchg_top`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising edge, that edge clears every data register and the select register to zero and sets `aOutEn`, `b1OutEn` and `b2OutEn` to 0. After that edge, `aOut`, `b1Out` and `b2Out` all read 0.
- R2: The first narrow-to-1B stage captures `aIn` only at an edge where `ldA1N` is 0. When `ldA1N` is 1, the stage keeps its word, and that word is the one that later reaches `b1Out`.
- R3: The second narrow-to-1B stage drives `b1Out`. It loads the word held in the first stage at every edge where `ldA2N` is 0, whatever the value of `ldA1N`. A word on `aIn` therefore needs two edges to reach `b1Out`.
- R4: At an edge where `ldA2N` is 0, `b2Out` takes `aIn`. A word loaded with `ldA1N`=0, `ldA2N`=1, followed at the next edge by a word loaded with `ldA1N`=1, `ldA2N`=0, gives `{b2Out,b1Out}` = {second, first} after the second edge.
- R5: At an edge where both `ldA1N` and `ldA2N` are 1, `b1Out` and `b2Out` keep their values.
- R6: The 1B capture register loads `b1In` only at an edge where `ldB1N` is 0. The 2B capture register loads `b2In` only at an edge where `ldB2N` is 0. Otherwise each keeps its word.
- R7: `pickB1` is sampled at each rising edge. After an edge where it was 1, `aOut` shows the 1B capture register. After an edge where it was 0, `aOut` shows the 2B capture register. A change of `pickB1` between edges does not change `aOut`.
- R8: `aOutEn` is 1 exactly when `aDriveN` was 0 at the previous edge. `b1OutEn` and `b2OutEn` are both 1 exactly when `bDriveN` was 0 at the previous edge. When both are driven low, both sides are enabled. When both are driven high, all three enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ldA1N | input | 1 | Active-low load of the first narrow-to-1B stage |
| ldA2N | input | 1 | Active-low load of the 2B register and of the second 1B stage |
| ldB1N | input | 1 | Active-low load of the 1B capture register |
| ldB2N | input | 1 | Active-low load of the 2B capture register |
| pickB1 | input | 1 | Select, sampled at the edge: 1 = 1B half to A, 0 = 2B half to A |
| aDriveN | input | 1 | Active-low request to drive port A, sampled at the edge |
| bDriveN | input | 1 | Active-low request to drive ports 1B and 2B, sampled at the edge |
| aIn | input | 12 | Data arriving on port A |
| aOut | output | 12 | Data driven onto port A |
| aOutEn | output | 1 | Drive enable for port A |
| b1In | input | 12 | Data arriving on port 1B |
| b1Out | output | 12 | Data driven onto port 1B |
| b1OutEn | output | 1 | Drive enable for port 1B |
| b2In | input | 12 | Data arriving on port 2B |
| b2Out | output | 12 | Data driven onto port 2B |
| b2OutEn | output | 1 | Drive enable for port 2B |

## Verification
The hardest case to reach from the ports is an edge where both narrow-side enables are low together. At that edge the second 1B stage must take the first stage's old word while the first stage takes a new one. A wrong implementation passes the word straight through and cannot be told apart from a correct one unless the two words differ. The stimulus table therefore sets up a known word in the first stage, then asserts both enables with a different word on A, and then asserts the 2B enable alone, so that both the forwarded old word and the newly held word become visible on 1B in turn.

// File: rtl/bxchg_pkg.sv
package bxchg_pkg;

  // Decoded, active-high strobes passed from control to the datapath
  typedef struct packed {
    logic loadA1;   // first narrow-to-1B stage
    logic loadA2;   // 2B register and second 1B stage
    logic loadB1;   // 1B capture register
    logic loadB2;   // 2B capture register
    logic pickB1;   // registered select toward port A
  } xchgStrobes_t;

endpackage

// File: rtl/bxchg_ctrl.sv
module bxchg_ctrl
  import bxchg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         ldA1N,
  input  logic         ldA2N,
  input  logic         ldB1N,
  input  logic         ldB2N,
  input  logic         pickB1,
  input  logic         aDriveN,
  input  logic         bDriveN,
  output xchgStrobes_t strb,
  output logic         aEnQ,
  output logic         bEnQ
);

  logic selQ;

  // Select and direction controls are sampled on the clock edge
  always_ff @(posedge clk) begin
    if (rst) begin
      selQ <= 1'b0;
      aEnQ <= 1'b0;
      bEnQ <= 1'b0;
    end else begin
      selQ <= pickB1;
      aEnQ <= ~aDriveN;
      bEnQ <= ~bDriveN;
    end
  end

  always_comb begin
    strb.loadA1 = ~ldA1N;
    strb.loadA2 = ~ldA2N;
    strb.loadB1 = ~ldB1N;
    strb.loadB2 = ~ldB2N;
    strb.pickB1 = selQ;
  end

  // R8: enables follow the active-low requests one edge later
  assert_oe_latency_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (aEnQ == !$past(aDriveN)) && (bEnQ == !$past(bDriveN)));

  // R1: reset leaves both sides undriven
  assert_reset_oe_R1: assert property (@(posedge clk)
    rst |=> !aEnQ && !bEnQ);

endmodule

// File: rtl/bxchg_dpath.sv
module bxchg_dpath
  import bxchg_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  xchgStrobes_t     strb,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] b1In,
  input  logic [WIDTH-1:0] b2In,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] b1Out,
  output logic [WIDTH-1:0] b2Out
);

  localparam int HALVES = 2;

  logic [WIDTH-1:0] a1Stage1;
  logic [WIDTH-1:0] a1Stage2;
  logic [WIDTH-1:0] a2Reg;

  logic [WIDTH-1:0] bInArr [HALVES];
  logic [WIDTH-1:0] bCap   [HALVES];
  logic             bLoad  [HALVES];

  // Narrow-to-wide: two stages toward 1B, one toward 2B
  always_ff @(posedge clk) begin
    if (rst) begin
      a1Stage1 <= '0;
      a1Stage2 <= '0;
      a2Reg    <= '0;
    end else begin
      if (strb.loadA1) a1Stage1 <= aIn;
      if (strb.loadA2) begin
        a1Stage2 <= a1Stage1;
        a2Reg    <= aIn;
      end
    end
  end

  assign b1Out = a1Stage2;
  assign b2Out = a2Reg;

  // Wide-to-narrow: one capture register per half
  assign bInArr[0] = b1In;
  assign bInArr[1] = b2In;
  assign bLoad[0]  = strb.loadB1;
  assign bLoad[1]  = strb.loadB2;

  for (genvar h = 0; h < HALVES; h++) begin : gHalf
    always_ff @(posedge clk) begin
      if (rst)           bCap[h] <= '0;
      else if (bLoad[h]) bCap[h] <= bInArr[h];
    end
  end

  assign aOut = strb.pickB1 ? bCap[0] : bCap[1];

  // R2: first stage holds while its enable is off
  assert_stage1_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strb.loadA1 |=> $stable(a1Stage1));

  // R3: second stage takes the earlier first-stage word
  assert_stage2_fwd_R3: assert property (@(posedge clk) disable iff (rst)
    strb.loadA2 |=> b1Out == $past(a1Stage1));

  // R4: 2B half captures the word on A
  assert_b2_capture_R4: assert property (@(posedge clk) disable iff (rst)
    strb.loadA2 |=> b2Out == $past(aIn));

  // R5: wide outputs hold with both narrow-side enables off
  assert_wide_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!strb.loadA1 && !strb.loadA2) |=> $stable(b1Out) && $stable(b2Out));

  // R6/R7: a fresh 1B capture reaches A when selected
  assert_b1_to_a_R6: assert property (@(posedge clk) disable iff (rst)
    strb.loadB1 |=> (!strb.pickB1 || aOut == $past(b1In)));

  // R7: a fresh 2B capture reaches A when selected
  assert_b2_to_a_R7: assert property (@(posedge clk) disable iff (rst)
    strb.loadB2 |=> (strb.pickB1 || aOut == $past(b2In)));

  // R1: data registers clear
  assert_reset_data_R1: assert property (@(posedge clk)
    rst |=> (aOut == '0) && (b1Out == '0) && (b2Out == '0));

endmodule

// File: rtl/bxchg_top.sv
module bxchg_top
  import bxchg_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ldA1N,
  input  logic             ldA2N,
  input  logic             ldB1N,
  input  logic             ldB2N,
  input  logic             pickB1,
  input  logic             aDriveN,
  input  logic             bDriveN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  input  logic [WIDTH-1:0] b1In,
  output logic [WIDTH-1:0] b1Out,
  output logic             b1OutEn,
  input  logic [WIDTH-1:0] b2In,
  output logic [WIDTH-1:0] b2Out,
  output logic             b2OutEn
);

  xchgStrobes_t strb;
  logic         bEnQ;

  bxchg_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ldA1N   (ldA1N),
    .ldA2N   (ldA2N),
    .ldB1N   (ldB1N),
    .ldB2N   (ldB2N),
    .pickB1  (pickB1),
    .aDriveN (aDriveN),
    .bDriveN (bDriveN),
    .strb    (strb),
    .aEnQ    (aOutEn),
    .bEnQ    (bEnQ)
  );

  bxchg_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .aIn   (aIn),
    .b1In  (b1In),
    .b2In  (b2In),
    .aOut  (aOut),
    .b1Out (b1Out),
    .b2Out (b2Out)
  );

  assign b1OutEn = bEnQ;
  assign b2OutEn = bEnQ;

endmodule

// File: tb/sim_bxchg_top.sv
module sim_bxchg_top;

  localparam int PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst, ldA1N, ldA2N, ldB1N, ldB2N, pickB1, aDriveN, bDriveN;
  logic [W-1:0] aIn, b1In, b2In, aOut, b1Out, b2Out;
  logic aOutEn, b1OutEn, b2OutEn;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  bxchg_top #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .ldA1N(ldA1N), .ldA2N(ldA2N), .ldB1N(ldB1N),
    .ldB2N(ldB2N), .pickB1(pickB1), .aDriveN(aDriveN), .bDriveN(bDriveN),
    .aIn(aIn), .aOut(aOut), .aOutEn(aOutEn),
    .b1In(b1In), .b1Out(b1Out), .b1OutEn(b1OutEn),
    .b2In(b2In), .b2Out(b2Out), .b2OutEn(b2OutEn)
  );

  typedef struct packed {
    logic         a1N;
    logic         a2N;
    logic [W-1:0] aVal;
    logic [W-1:0] expB1;
    logic [W-1:0] expB2;
    logic [3:0]   req;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b1, 12'h111, 12'h000, 12'h000, 4'd2},  // R2 first word held
    '{1'b1, 1'b0, 12'h222, 12'h111, 12'h222, 4'd4},  // R4 pair appears
    '{1'b1, 1'b1, 12'hABC, 12'h111, 12'h222, 4'd5},  // R5 hold
    '{1'b0, 1'b1, 12'h333, 12'h111, 12'h222, 4'd2},  // R2
    '{1'b1, 1'b0, 12'h444, 12'h333, 12'h444, 4'd4},  // R4
    '{1'b0, 1'b0, 12'h555, 12'h333, 12'h555, 4'd3},  // R3 old stage word forwarded
    '{1'b1, 1'b0, 12'h666, 12'h555, 12'h666, 4'd3},  // R3 two edges to 1B
    '{1'b0, 1'b1, 12'hFFF, 12'h555, 12'h666, 4'd5},  // R5 wide side unchanged
    '{1'b1, 1'b0, 12'h000, 12'hFFF, 12'h000, 4'd4}   // R4
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(PERIOD * 5000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; ldA1N = 1'b1; ldA2N = 1'b1; ldB1N = 1'b1; ldB2N = 1'b1;
    pickB1 = 1'b0; aDriveN = 1'b1; bDriveN = 1'b1;
    aIn = '0; b1In = '0; b2In = '0;
    tick(); tick();
    rst = 1'b0;
    // R1: reset state
    chk("R1 aOut", aOut, '0);
    chk("R1 b1Out", b1Out, '0);
    chk("R1 b2Out", b2Out, '0);
    chk("R1 enables", {9'd0, aOutEn, b1OutEn, b2OutEn}, '0);

    // Table walk, narrow to wide
    for (int i = 0; i < 9; i++) begin
      ldA1N = VECS[i].a1N; ldA2N = VECS[i].a2N; aIn = VECS[i].aVal;
      tick();
      checks++;
      if (b1Out !== VECS[i].expB1 || b2Out !== VECS[i].expB2) begin
        fails++;
        $display("FAIL R%0d row %0d actual=%h_%h expected=%h_%h",
                 VECS[i].req, i, b2Out, b1Out, VECS[i].expB2, VECS[i].expB1);
      end
    end
    ldA1N = 1'b1; ldA2N = 1'b1;

    // R8: registered enables
    aDriveN = 1'b0; bDriveN = 1'b1;
    #1;
    chk("R8 before edge", {11'd0, aOutEn}, 12'd0);
    tick();
    chk("R8 A only", {9'd0, aOutEn, b1OutEn, b2OutEn}, 12'b100);
    aDriveN = 1'b0; bDriveN = 1'b0;
    tick();
    chk("R8 both low", {9'd0, aOutEn, b1OutEn, b2OutEn}, 12'b111);
    aDriveN = 1'b1; bDriveN = 1'b0;
    tick();
    chk("R8 B only", {9'd0, aOutEn, b1OutEn, b2OutEn}, 12'b011);
    aDriveN = 1'b1; bDriveN = 1'b1;
    tick();
    chk("R8 both high", {9'd0, aOutEn, b1OutEn, b2OutEn}, 12'b000);

    // R6 / R7: wide to narrow
    b1In = 12'h5A5; b2In = 12'h3C3; ldB1N = 1'b0; ldB2N = 1'b0; pickB1 = 1'b1;
    tick();
    chk("R6 1B captured", aOut, 12'h5A5);
    ldB1N = 1'b1; ldB2N = 1'b1; b1In = 12'h000; pickB1 = 1'b0;
    #1;
    chk("R7 select waits for edge", aOut, 12'h5A5);
    tick();
    chk("R7 2B selected", aOut, 12'h3C3);
    b1In = 12'h777; pickB1 = 1'b1;
    tick();
    chk("R6 1B held", aOut, 12'h5A5);
    ldB2N = 1'b0; b2In = 12'h123; pickB1 = 1'b0;
    tick();
    chk("R6 2B reload", aOut, 12'h123);
    ldB2N = 1'b1;

    // R1: reset mid-run
    aDriveN = 1'b0; bDriveN = 1'b0;
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 aOut after run", aOut, '0);
    chk("R1 b1Out after run", b1Out, '0);
    chk("R1 b2Out after run", b2Out, '0);
    chk("R1 enables after run", {9'd0, aOutEn, b1OutEn, b2OutEn}, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule